// File: doc/BRIEF.md
# Clock Mode Control Register

This block is the 8-bit software-visible control register of an on-chip clock generator. A simple register bus writes and reads it. The block enforces the access rules that protect the clock tree. The reference range and the reference-type fields can be set only once after reset. If the first write after reset picks an internal clock mode, the external modes stay blocked until the next reset. A clock mode write is dropped while the previous mode change has not finished.

The register keeps the mode that software asked for apart from the mode that drives the clock multiplexer. The effective mode follows the requested mode one clock after the change is allowed. A request for the external bypass mode waits until the external reference reports stable. Status inputs stand in for the analog oscillator, the frequency-locked loop and the multiplexer. They report reference stability, completion of a mode change and entry into off mode. From the register fields and these inputs the block drives the oscillator gain and range controls, the loop prescale factor, the oscillator keep-alive for off mode and the loss-of-clock detect enable.

Top module: `clk_mode_ctrl_reg`

## Requirements
- R1: After reset, reads return 0x44, the effective mode is 00, high_range_o is 1, high_gain_o is 0, loc_det_en_o is 1 and osc_off_en_o is 0.
- R2: The register layout is bit 7 high gain, bit 6 high range, bit 5 crystal reference select, bits 4:3 requested mode, bit 2 keep oscillator in off mode and bit 1 loss-of-clock disable. Bit 0 always reads 0. Bits 7, 2 and 1 take every write.
- R3: Bits 6 and 5 take only the first write after reset. Later writes leave them unchanged.
- R4: When the first write after reset carries a mode of 00 or 01, no later write can set the mode field to 10 or 11 before the next reset.
- R5: A request for mode 10 (bypass, external reference) does not reach eff_mode_o while ref_stable_i is 0. It appears one clock after ref_stable_i is 1.
- R6: A write that changes the requested mode starts a mode change. While that change is incomplete (until mode_done_i is sampled high), writes leave the mode field unchanged.
- R7: Holding off_mode_i high changes neither the requested mode nor the effective mode.
- R8: presc_factor_o is 1 when the effective mode is 1X and bit 6 is 1. It is 64 when the effective mode is 1X and bit 6 is 0, and 64 in modes 00 and 01 whatever bit 6 holds.
- R9: osc_off_en_o is high only with off_mode_i and ref_stable_i high. With bit 2 set, the effective mode must also be 1X. With bit 2 clear, osc_req_i must also be high and the effective mode must be 10.
- R10: loc_det_en_o is the inverse of bit 1.
- R11: Requests for modes 00, 01 and 11 reach eff_mode_o one clock after they are accepted, whatever the value of ref_stable_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Register read value |
| ref_stable_i | input | 1 | External reference reports stable |
| mode_done_i | input | 1 | Clock multiplexer finished the mode change |
| off_mode_i | input | 1 | Clock generator is in off mode |
| osc_req_i | input | 1 | External request to keep the oscillator running |
| eff_mode_o | output | 2 | Effective clock mode driving the multiplexer |
| high_gain_o | output | 1 | Oscillator high-amplitude select |
| high_range_o | output | 1 | Oscillator high-frequency range select |
| presc_factor_o | output | 7 | Loop prescale factor (1 or 64) |
| osc_off_en_o | output | 1 | Keep oscillator enabled in off mode |
| loc_det_en_o | output | 1 | Loss-of-clock detection enable |

## Verification
The bench builds the block with its default parameters: reset value 0x44, external-mode lockout on, prescale factors 64 and 1 in a 7-bit output. With the lockout variant on, the permanent block on external modes after an early internal choice can be tested. The 0x44 reset value puts the range bit at 1, so a factor of 64 in mode 00 shows that range has no effect there. Each scenario starts from a fresh reset, because the write-once and lockout state clears only on reset.

// File: rtl/ckm_pkg.sv
package ckm_pkg;

   typedef enum logic [1:0] {
      CKM_SELF    = 2'b00,
      CKM_INT_FLL = 2'b01,
      CKM_BYPASS  = 2'b10,
      CKM_EXT_FLL = 2'b11
   } ckm_mode_e;

   localparam int unsigned CKM_REG_W   = 8;
   localparam int unsigned CKM_GAIN_B  = 7;
   localparam int unsigned CKM_RANGE_B = 6;
   localparam int unsigned CKM_REFS_B  = 5;
   localparam int unsigned CKM_MODE_LO = 3;
   localparam int unsigned CKM_MODE_HI = 4;
   localparam int unsigned CKM_KEEP_B  = 2;
   localparam int unsigned CKM_LOCD_B  = 1;

endpackage

// File: rtl/ckm_field_regs.sv
module ckm_field_regs
   import ckm_pkg::*;
#(
   parameter logic [CKM_REG_W-1:0] RESET_VAL = 8'h44,
   parameter logic [CKM_REG_W-1:0] ONCE_MASK = 8'h60,
   parameter logic [CKM_REG_W-1:0] NONE_MASK = 8'h19
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 wr_en_i,
   input  logic [CKM_REG_W-1:0] wr_data_i,
   output logic [CKM_REG_W-1:0] fld_o,
   output logic                 first_done_o
);

   logic first_done_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      first_done_q <= 1'b0;
      else if (wr_en_i) first_done_q <= 1'b1;
   end

   for (genvar i = 0; i < CKM_REG_W; i++) begin : g_bit
      if (NONE_MASK[i]) begin : g_none
         assign fld_o[i] = 1'b0;
      end else if (ONCE_MASK[i]) begin : g_once
         logic q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)                       q <= RESET_VAL[i];
            else if (wr_en_i && !first_done_q) q <= wr_data_i[i];
         end
         assign fld_o[i] = q;
      end else begin : g_plain
         logic q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)      q <= RESET_VAL[i];
            else if (wr_en_i) q <= wr_data_i[i];
         end
         assign fld_o[i] = q;
      end
   end

   assign first_done_o = first_done_q;

   initial begin
      assert ((ONCE_MASK & NONE_MASK) == '0)
         else $error("ckm_field_regs: a bit cannot be both write-once and absent");
   end

   assert_once_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      first_done_q |=> $stable(fld_o & ONCE_MASK));

endmodule

// File: rtl/ckm_mode_ctrl.sv
module ckm_mode_ctrl
   import ckm_pkg::*;
#(
   parameter logic [1:0] RESET_MODE = 2'b00,
   parameter bit         LOCKOUT_EN = 1'b1
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       wr_en_i,
   input  logic [1:0] wr_mode_i,
   input  logic       first_wr_i,
   input  logic       ref_stable_i,
   input  logic       mode_done_i,
   input  logic       off_mode_i,
   output logic [1:0] req_mode_o,
   output logic [1:0] eff_mode_o
);

   ckm_mode_e req_q, eff_q;
   logic      busy_q;
   logic      lock_q;
   logic      accept;
   logic      may_apply;

   if (LOCKOUT_EN) begin : g_lock
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)                                     lock_q <= 1'b0;
         else if (wr_en_i && first_wr_i && !wr_mode_i[1]) lock_q <= 1'b1;
      end
   end else begin : g_nolock
      assign lock_q = 1'b0;
   end

   assign accept    = wr_en_i && !busy_q && !(lock_q && wr_mode_i[1]);
   assign may_apply = (req_q != eff_q) && ((req_q != CKM_BYPASS) || ref_stable_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         req_q  <= ckm_mode_e'(RESET_MODE);
         eff_q  <= ckm_mode_e'(RESET_MODE);
         busy_q <= 1'b0;
      end else begin
         if (accept) req_q <= ckm_mode_e'(wr_mode_i);
         if (accept && (ckm_mode_e'(wr_mode_i) != req_q)) busy_q <= 1'b1;
         else if (mode_done_i)                            busy_q <= 1'b0;
         if (may_apply) eff_q <= req_q;
      end
   end

   assign req_mode_o = req_q;
   assign eff_mode_o = eff_q;

   assert_lockout_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lock_q |-> !req_q[1]);

   assert_bypass_wait_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (eff_q != CKM_BYPASS && !ref_stable_i) |=> (eff_q != CKM_BYPASS));

   assert_busy_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_q && wr_en_i) |=> $stable(req_q));

   assert_off_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (off_mode_i && !wr_en_i) |=> $stable(req_q));

endmodule

// File: rtl/clk_mode_ctrl_reg.sv
module clk_mode_ctrl_reg
   import ckm_pkg::*;
#(
   parameter logic [7:0] RESET_VAL     = 8'h44,
   parameter bit         LOCKOUT_EN    = 1'b1,
   parameter int         PRESC_W       = 7,
   parameter int         LOW_PRESCALE  = 64,
   parameter int         HIGH_PRESCALE = 1
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               wr_en_i,
   input  logic [7:0]         wr_data_i,
   output logic [7:0]         rd_data_o,
   input  logic               ref_stable_i,
   input  logic               mode_done_i,
   input  logic               off_mode_i,
   input  logic               osc_req_i,
   output logic [1:0]         eff_mode_o,
   output logic               high_gain_o,
   output logic               high_range_o,
   output logic [PRESC_W-1:0] presc_factor_o,
   output logic               osc_off_en_o,
   output logic               loc_det_en_o
);

   localparam logic [7:0] ONCE_MASK = (8'd1 << CKM_RANGE_B) | (8'd1 << CKM_REFS_B);
   localparam logic [7:0] MODE_MASK = (8'd1 << CKM_MODE_HI) | (8'd1 << CKM_MODE_LO);
   localparam logic [7:0] NONE_MASK = MODE_MASK | 8'd1;
   localparam logic [PRESC_W-1:0] LOW_F  = PRESC_W'(LOW_PRESCALE);
   localparam logic [PRESC_W-1:0] HIGH_F = PRESC_W'(HIGH_PRESCALE);

   logic [7:0] fld;
   logic       first_done;
   logic [1:0] req_mode;
   logic [1:0] eff_mode;
   logic       keep_ok;

   initial begin
      assert (PRESC_W >= $clog2(LOW_PRESCALE + 1) && PRESC_W >= $clog2(HIGH_PRESCALE + 1))
         else $error("clk_mode_ctrl_reg: PRESC_W too narrow for the prescale factors");
      assert (LOW_PRESCALE > 0 && HIGH_PRESCALE > 0)
         else $error("clk_mode_ctrl_reg: prescale factors must be positive");
   end

   ckm_field_regs #(
      .RESET_VAL (RESET_VAL),
      .ONCE_MASK (ONCE_MASK),
      .NONE_MASK (NONE_MASK)
   ) i_fields (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .wr_en_i      (wr_en_i),
      .wr_data_i    (wr_data_i),
      .fld_o        (fld),
      .first_done_o (first_done)
   );

   ckm_mode_ctrl #(
      .RESET_MODE (RESET_VAL[CKM_MODE_HI:CKM_MODE_LO]),
      .LOCKOUT_EN (LOCKOUT_EN)
   ) i_mode (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .wr_en_i      (wr_en_i),
      .wr_mode_i    (wr_data_i[CKM_MODE_HI:CKM_MODE_LO]),
      .first_wr_i   (!first_done),
      .ref_stable_i (ref_stable_i),
      .mode_done_i  (mode_done_i),
      .off_mode_i   (off_mode_i),
      .req_mode_o   (req_mode),
      .eff_mode_o   (eff_mode)
   );

   assign rd_data_o    = fld | (8'(req_mode) << CKM_MODE_LO);
   assign eff_mode_o   = eff_mode;
   assign high_gain_o  = fld[CKM_GAIN_B];
   assign high_range_o = fld[CKM_RANGE_B];
   assign loc_det_en_o = !fld[CKM_LOCD_B];

   always_comb begin
      if (eff_mode[1] && fld[CKM_RANGE_B]) presc_factor_o = HIGH_F;
      else                                 presc_factor_o = LOW_F;
   end

   always_comb begin
      if (fld[CKM_KEEP_B]) keep_ok = eff_mode[1];
      else                 keep_ok = osc_req_i && (eff_mode == CKM_BYPASS);
   end

   assign osc_off_en_o = off_mode_i && ref_stable_i && keep_ok;

   assert_presc_internal_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !eff_mode_o[1] |-> (presc_factor_o == LOW_F));

   assert_osc_off_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!off_mode_i || !ref_stable_i) |-> !osc_off_en_o);

   assert_locd_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && wr_data_i[CKM_LOCD_B]) |=> !loc_det_en_o);

   assert_bit0_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rd_data_o[0]);

endmodule

// File: tb/test_clk_mode_ctrl_reg.sv
module test_clk_mode_ctrl_reg;

   logic       clk = 1'b0;
   logic       rst_ni = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic       ref_stable = 1'b0;
   logic       mode_done = 1'b0;
   logic       off_mode = 1'b0;
   logic       osc_req = 1'b0;
   logic [1:0] eff_mode;
   logic       high_gain, high_range, osc_off_en, loc_det_en;
   logic [6:0] presc;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   clk_mode_ctrl_reg #(
      .RESET_VAL     (8'h44),
      .LOCKOUT_EN    (1'b1),
      .PRESC_W       (7),
      .LOW_PRESCALE  (64),
      .HIGH_PRESCALE (1)
   ) i_clk_mode_ctrl_reg (
      .clk_i          (clk),
      .rst_ni         (rst_ni),
      .wr_en_i        (wr_en),
      .wr_data_i      (wr_data),
      .rd_data_o      (rd_data),
      .ref_stable_i   (ref_stable),
      .mode_done_i    (mode_done),
      .off_mode_i     (off_mode),
      .osc_req_i      (osc_req),
      .eff_mode_o     (eff_mode),
      .high_gain_o    (high_gain),
      .high_range_o   (high_range),
      .presc_factor_o (presc),
      .osc_off_en_o   (osc_off_en),
      .loc_det_en_o   (loc_det_en)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_ni = 1'b0; wr_en = 1'b0; wr_data = '0; ref_stable = 1'b0;
      mode_done = 1'b0; off_mode = 1'b0; osc_req = 1'b0;
      repeat (2) @(negedge clk);
      rst_ni = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] v);
      wr_en = 1'b1; wr_data = v;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic done_pulse();
      mode_done = 1'b1;
      @(negedge clk);
      mode_done = 1'b0;
   endtask

   task automatic t_reset_state();
      do_reset();
      chk("R1 read value", rd_data, 8'h44);
      chk("R1 effective mode", 8'(eff_mode), 8'h00);
      chk("R1 high range", 8'(high_range), 8'h01);
      chk("R1 high gain", 8'(high_gain), 8'h00);
      chk("R1 loss-of-clock enable", 8'(loc_det_en), 8'h01);
      chk("R1 osc off enable", 8'(osc_off_en), 8'h00);
      chk("R8 factor in mode 00 with range 1", 8'(presc), 8'd64);
   endtask

   task automatic t_write_once();
      do_reset();
      wr(8'hD8);
      chk("R2 first write read", rd_data, 8'hD8);
      chk("R2 high gain set", 8'(high_gain), 8'h01);
      @(negedge clk);
      chk("R11 mode 11 applied without reference", 8'(eff_mode), 8'h03);
      chk("R8 factor high range mode 11", 8'(presc), 8'd1);
      done_pulse();
      wr(8'h18);
      chk("R3 range kept after second write", rd_data, 8'h58);
      chk("R2 high gain cleared", 8'(high_gain), 8'h00);
      wr(8'h38);
      chk("R3 reference select kept", rd_data, 8'h58);
      wr(8'h5B);
      chk("R2 bit0 reads zero", rd_data, 8'h5A);
      chk("R10 detection disabled", 8'(loc_det_en), 8'h00);
      wr(8'h58);
      chk("R10 detection enabled again", 8'(loc_det_en), 8'h01);
   endtask

   task automatic t_lockout();
      do_reset();
      wr(8'h08);
      chk("R4 first internal write", rd_data, 8'h08);
      @(negedge clk);
      chk("R11 mode 01 applied", 8'(eff_mode), 8'h01);
      done_pulse();
      wr(8'h18);
      chk("R4 mode 11 blocked", rd_data, 8'h08);
      wr(8'h10);
      chk("R4 mode 10 blocked", rd_data, 8'h08);
      chk("R4 effective mode unchanged", 8'(eff_mode), 8'h01);
      wr(8'h00);
      chk("R4 internal mode still writable", rd_data, 8'h00);
      @(negedge clk);
      chk("R11 mode 00 applied", 8'(eff_mode), 8'h00);
   endtask

   task automatic t_bypass_busy();
      do_reset();
      wr(8'h50);
      chk("R5 bypass request readable", rd_data, 8'h50);
      repeat (3) @(negedge clk);
      chk("R5 bypass pending without reference", 8'(eff_mode), 8'h00);
      wr(8'h48);
      chk("R6 write ignored while change incomplete", rd_data, 8'h50);
      off_mode = 1'b1; osc_req = 1'b1;
      ref_stable = 1'b1;
      chk("R5 not yet applied at reference rise", 8'(eff_mode), 8'h00);
      @(negedge clk);
      chk("R5 bypass applied one clock later", 8'(eff_mode), 8'h02);
      chk("R9 keep off, request high, mode 10", 8'(osc_off_en), 8'h01);
      osc_req = 1'b0;
      #1;
      chk("R9 keep off, request low", 8'(osc_off_en), 8'h00);
      repeat (3) @(negedge clk);
      chk("R7 requested mode kept in off mode", rd_data, 8'h50);
      chk("R7 effective mode kept in off mode", 8'(eff_mode), 8'h02);
      off_mode = 1'b0;
      done_pulse();
      wr(8'h40);
      chk("R6 write accepted after completion", rd_data, 8'h40);
      @(negedge clk);
      chk("R6 new mode applied", 8'(eff_mode), 8'h00);
   endtask

   task automatic t_osc_keep();
      do_reset();
      ref_stable = 1'b1;
      wr(8'h5C);
      @(negedge clk);
      chk("R11 mode 11 applied", 8'(eff_mode), 8'h03);
      off_mode = 1'b1; osc_req = 1'b0;
      #1;
      chk("R9 keep on, mode 11, reference stable", 8'(osc_off_en), 8'h01);
      ref_stable = 1'b0;
      #1;
      chk("R9 keep on, reference lost", 8'(osc_off_en), 8'h00);
      off_mode = 1'b0; ref_stable = 1'b1;
      #1;
      chk("R9 not in off mode", 8'(osc_off_en), 8'h00);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      t_reset_state();
      t_write_once();
      t_lockout();
      t_bypass_busy();
      t_osc_keep();
      finished = 1'b1;
      summary();
      $finish;
   end

endmodule